// File: doc/BRIEF.md
# I2C Address XOR Translator

This block sits between the master side and the slave side of an I2C bus and rewrites the 7-bit target address of each transaction while it is on the wire. Each address bit is XORed with one bit of a configured 7-bit translation value as it crosses from the master side to the slave side. The R/W bit, the acknowledge slots and all data bytes in either direction pass through unchanged. Several identical slaves can therefore sit behind separate translators and appear at different addresses.

Each bus line is modelled as an open-drain pair: a sampled line input plus a registered drive-low enable. A system clock much faster than SCL oversamples both buses. The clock line is bridged as a wired-AND in both directions. The data line is bridged in one direction at a time, chosen by a bit tracker that follows START, STOP, byte and acknowledge boundaries on the master side.

An enable input controls the link. While enable is low the two buses are disconnected. A rising edge of enable starts a capture window of fixed length. At the end of the window the translation value is latched, or zero is latched if pass-through is requested, and the ready output rises. From that point the two buses are connected.

Top module: `i2c_xor_xlate`

## Requirements
- R1: While enable is low, ready is low and all four drive-low enables (m_scl_oe, m_sda_oe, s_scl_oe, s_sda_oe) are released, so neither bus sees the other.
- R2: After enable is seen high following a low, ready stays low for CAP_CYCLES clocks, then rises and stays high for as long as enable stays high.
- R3: The translation value is {key_hi, key_lo}: key_hi supplies bits 6..4 and key_lo supplies bits 3..0. It is latched at the end of the capture window. Later changes on key_hi or key_lo have no effect until the next rising edge of enable.
- R4: The first byte after a START carries the address MSB first. The slave side receives each address bit k (6 down to 0) XORed with translation bit k.
- R5: The R/W bit (bit 0 of the first byte) and every byte the master writes after the address reach the slave side unchanged.
- R6: In the acknowledge slot that follows the address byte and each written byte, the slave-side SDA low is reflected onto the master-side SDA.
- R7: After an address with R/W = 1, the slave's data bits are reflected onto the master side. The master's ACK (SDA low) or NACK (SDA high) in the ninth slot is forwarded to the slave side.
- R8: If pass_req is high when the capture window ends, the address reaches the slave side unmodified.
- R9: A repeated START restarts address tracking, so the address byte that follows it is translated again.
- R10: START and STOP conditions issued on the master side appear on the slave side.
- R11: SCL is a wired-AND across both sides, so a slave-side device holding SCL low makes master-side SCL low.
- R12: Master-side activity while ready is low does not reach the slave side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Link enable; a rising edge restarts configuration |
| pass_req | input | 1 | Request bridging without address change |
| key_hi | input | HI_W | Upper field of the translation value |
| key_lo | input | ADDR_W-HI_W | Lower field of the translation value |
| ready | output | 1 | High once the value is latched and the link is connected |
| m_scl_i | input | 1 | Master-side SCL line level |
| m_sda_i | input | 1 | Master-side SDA line level |
| m_scl_oe | output | 1 | Pull master-side SCL low |
| m_sda_oe | output | 1 | Pull master-side SDA low |
| s_scl_i | input | 1 | Slave-side SCL line level |
| s_sda_i | input | 1 | Slave-side SDA line level |
| s_scl_oe | output | 1 | Pull slave-side SCL low |
| s_sda_oe | output | 1 | Pull slave-side SDA low |

## Verification
The bound checker watches the enable and ready handshake on every cycle: links released whenever ready is low, ready low right after enable rises, ready held while enable stays high. It also checks that neither the clock link nor the data link ever drives both sides at once, which would latch a line low. Whether an address bit is actually flipped, whether data and acknowledge bits cross in the right direction, and whether a late change of the translation value is ignored are shown only by the bench. In the bench, a slave model decodes the slave-side bus and compares each byte against what the master driver predicted.

// File: rtl/i2c_xlate_pkg.sv
package i2c_xlate_pkg;

    // Transfer phase tracked on the master side of the bus.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no transfer tracked: data forwarded as-is
        PH_ADDR = 2'd1,   // first byte after a START
        PH_WR   = 2'd2,   // master writes bytes
        PH_RD   = 2'd3    // slave returns bytes
    } phase_e;

    // Registered drive-low enables of both buses.
    typedef struct packed {
        logic m_scl;
        logic m_sda;
        logic s_scl;
        logic s_sda;
    } link_t;

endpackage

// File: rtl/i2c_xlate_cfg.sv
module i2c_xlate_cfg #(
    parameter int ADDR_W     = 7,
    parameter int HI_W       = 3,
    parameter int CAP_CYCLES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     pass_req,
    input  logic [HI_W-1:0]          key_hi,
    input  logic [ADDR_W-HI_W-1:0]   key_lo,
    output logic                     ready,
    output logic [ADDR_W-1:0]        key
);

    localparam int CNT_W = $clog2(CAP_CYCLES + 1);

    typedef struct packed {
        logic              en;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              rdy;
        logic [ADDR_W-1:0] key;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        cfg_d.en = enable;
        if (!enable) begin
            cfg_d.busy = 1'b0;
            cfg_d.rdy  = 1'b0;
            cfg_d.cnt  = '0;
        end else if (!cfg_q.en) begin
            // rising edge: restart the capture window
            cfg_d.busy = 1'b1;
            cfg_d.rdy  = 1'b0;
            cfg_d.cnt  = '0;
        end else if (cfg_q.busy) begin
            if (cfg_q.cnt == CNT_W'(CAP_CYCLES - 1)) begin
                cfg_d.busy = 1'b0;
                cfg_d.rdy  = 1'b1;
                cfg_d.key  = pass_req ? '0 : {key_hi, key_lo};
            end else begin
                cfg_d.cnt = cfg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ready = cfg_q.rdy;
    assign key   = cfg_q.key;

endmodule

// File: rtl/i2c_xlate_track.sv
module i2c_xlate_track
    import i2c_xlate_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              scl,
    input  logic              sda,
    input  logic [ADDR_W-1:0] key,
    output logic              flip,
    output logic              reverse
);

    localparam int ACK_SLOT = ADDR_W + 1;
    localparam int CNT_W    = $clog2(ACK_SLOT + 1);

    typedef struct packed {
        logic             scl_p;
        logic             sda_p;
        phase_e           phase;
        logic             armed;   // first SCL fall after START seen
        logic [CNT_W-1:0] bitc;
        logic             rw;
        logic             ack;
    } trk_t;

    trk_t trk_d, trk_q;

    logic rise, fall, start_c, stop_c;

    always_comb begin
        rise    = scl && !trk_q.scl_p;
        fall    = !scl && trk_q.scl_p;
        start_c = scl && trk_q.scl_p && trk_q.sda_p && !sda;
        stop_c  = scl && trk_q.scl_p && !trk_q.sda_p && sda;
    end

    always_comb begin
        trk_d       = trk_q;
        trk_d.scl_p = scl;
        trk_d.sda_p = sda;
        if (!active) begin
            trk_d.phase = PH_IDLE;
            trk_d.armed = 1'b0;
            trk_d.bitc  = '0;
        end else if (start_c) begin
            trk_d.phase = PH_ADDR;
            trk_d.armed = 1'b0;
            trk_d.bitc  = '0;
            trk_d.rw    = 1'b0;
            trk_d.ack   = 1'b0;
        end else if (stop_c) begin
            trk_d.phase = PH_IDLE;
            trk_d.armed = 1'b0;
            trk_d.bitc  = '0;
        end else if (fall && trk_q.phase != PH_IDLE) begin
            if (!trk_q.armed) begin
                trk_d.armed = 1'b1;
            end else if (trk_q.bitc == CNT_W'(ACK_SLOT)) begin
                trk_d.bitc = '0;
                if (!trk_q.ack) begin
                    trk_d.phase = PH_IDLE;    // NACK ends tracking
                end else if (trk_q.phase == PH_ADDR) begin
                    trk_d.phase = trk_q.rw ? PH_RD : PH_WR;
                end
            end else begin
                trk_d.bitc = trk_q.bitc + 1'b1;
            end
        end else if (rise && trk_q.phase != PH_IDLE && trk_q.armed) begin
            if (trk_q.phase == PH_ADDR && trk_q.bitc == CNT_W'(ADDR_W)) begin
                trk_d.rw = sda;
            end
            if (trk_q.bitc == CNT_W'(ACK_SLOT)) begin
                trk_d.ack = !sda;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q       <= '0;
            trk_q.scl_p <= 1'b1;
            trk_q.sda_p <= 1'b1;
            trk_q.phase <= PH_IDLE;
        end else begin
            trk_q <= trk_d;
        end
    end

    // address bit k goes out at bit count ADDR_W-1-k (MSB first)
    always_comb begin
        flip = 1'b0;
        if (trk_q.phase == PH_ADDR && trk_q.armed) begin
            for (int i = 0; i < ADDR_W; i++) begin
                if (trk_q.bitc == CNT_W'(i)) begin
                    flip = key[ADDR_W-1-i];
                end
            end
        end
    end

    always_comb begin
        if (trk_q.phase == PH_RD) begin
            reverse = trk_q.armed && (trk_q.bitc != CNT_W'(ACK_SLOT));
        end else begin
            reverse = (trk_q.phase != PH_IDLE) && trk_q.armed &&
                      (trk_q.bitc == CNT_W'(ACK_SLOT));
        end
    end

endmodule

// File: rtl/i2c_xor_xlate.sv
module i2c_xor_xlate
    import i2c_xlate_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int HI_W       = 3,
    parameter int CAP_CYCLES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   pass_req,
    input  logic [HI_W-1:0]        key_hi,
    input  logic [ADDR_W-HI_W-1:0] key_lo,
    output logic                   ready,
    input  logic                   m_scl_i,
    input  logic                   m_sda_i,
    output logic                   m_scl_oe,
    output logic                   m_sda_oe,
    input  logic                   s_scl_i,
    input  logic                   s_sda_i,
    output logic                   s_scl_oe,
    output logic                   s_sda_oe
);

    logic [ADDR_W-1:0] key;
    logic              flip;
    logic              reverse;

    i2c_xlate_cfg #(
        .ADDR_W     (ADDR_W),
        .HI_W       (HI_W),
        .CAP_CYCLES (CAP_CYCLES)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pass_req (pass_req),
        .key_hi   (key_hi),
        .key_lo   (key_lo),
        .ready    (ready),
        .key      (key)
    );

    i2c_xlate_track #(
        .ADDR_W (ADDR_W)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (ready),
        .scl     (m_scl_i),
        .sda     (m_sda_i),
        .key     (key),
        .flip    (flip),
        .reverse (reverse)
    );

    link_t lnk_d, lnk_q;
    logic  m_scl_ext, s_scl_ext, m_sda_ext, s_sda_ext;

    // A line is "externally low" when it is low and this block is not the
    // one pulling it; only such lows are carried to the other side.
    always_comb begin
        m_scl_ext = !m_scl_i && !lnk_q.m_scl;
        s_scl_ext = !s_scl_i && !lnk_q.s_scl;
        m_sda_ext = !m_sda_i && !lnk_q.m_sda;
        s_sda_ext = !s_sda_i && !lnk_q.s_sda;
    end

    always_comb begin
        lnk_d = '0;
        if (ready) begin
            lnk_d.s_scl = m_scl_ext;
            lnk_d.m_scl = s_scl_ext && !m_scl_ext;
            if (reverse) begin
                lnk_d.m_sda = s_sda_ext;
            end else begin
                lnk_d.s_sda = m_sda_ext ^ flip;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lnk_q <= '0;
        end else begin
            lnk_q <= lnk_d;
        end
    end

    assign m_scl_oe = lnk_q.m_scl;
    assign m_sda_oe = lnk_q.m_sda;
    assign s_scl_oe = lnk_q.s_scl;
    assign s_sda_oe = lnk_q.s_sda;

endmodule

// File: rtl/i2c_xlate_chk.sv
module i2c_xlate_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic ready,
    input logic m_scl_oe,
    input logic m_sda_oe,
    input logic s_scl_oe,
    input logic s_sda_oe
);

    assert_off_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ready);

    assert_links_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !(m_scl_oe || m_sda_oe || s_scl_oe || s_sda_oe));

    assert_capture_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> !ready);

    assert_ready_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && enable) |=> ready);

    assert_no_scl_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_scl_oe && s_scl_oe));

    assert_sda_one_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_sda_oe && s_sda_oe));

endmodule

bind i2c_xor_xlate i2c_xlate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .ready    (ready),
    .m_scl_oe (m_scl_oe),
    .m_sda_oe (m_sda_oe),
    .s_scl_oe (s_scl_oe),
    .s_sda_oe (s_sda_oe)
);

// File: tb/sim_i2c_xor_xlate.sv
`timescale 1ns/1ps
module sim_i2c_xor_xlate;

    localparam int CAP = 16;
    localparam int Q   = 10;   // clocks per SCL half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic pass_req = 1'b0;
    logic [2:0] key_hi = '0;
    logic [3:0] key_lo = '0;
    logic ready;
    logic m_scl_oe, m_sda_oe, s_scl_oe, s_sda_oe;
    // bench drivers: 1 pulls the line low
    logic mdr_scl = 1'b0, mdr_sda = 1'b0, sdr_scl = 1'b0, sdr_sda = 1'b0;
    logic m_scl, m_sda, s_scl, s_sda;

    assign m_scl = !(mdr_scl || m_scl_oe);
    assign m_sda = !(mdr_sda || m_sda_oe);
    assign s_scl = !(sdr_scl || s_scl_oe);
    assign s_sda = !(sdr_sda || s_sda_oe);

    always #4 clk = !clk;   // 125 MHz

    i2c_xor_xlate #(.CAP_CYCLES(CAP)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pass_req(pass_req),
        .key_hi(key_hi), .key_lo(key_lo), .ready(ready),
        .m_scl_i(m_scl), .m_sda_i(m_sda), .m_scl_oe(m_scl_oe), .m_sda_oe(m_sda_oe),
        .s_scl_i(s_scl), .s_sda_i(s_sda), .s_scl_oe(s_scl_oe), .s_sda_oe(s_sda_oe)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // ---------------- slave model + monitor ----------------
    logic       ps_scl = 1'b1, ps_sda = 1'b1;
    int         bitn = 0;
    bit         first = 1'b0, rd_ph = 1'b0, in_xfer = 1'b0, mack = 1'b0;
    logic [7:0] shreg = '0, tx = '0, rd_val = 8'hA5;
    int         st_cnt = 0, sp_cnt = 0;

    always @(negedge clk) begin
        if (s_scl && ps_scl && ps_sda && !s_sda) begin
            st_cnt++; in_xfer = 1'b1; bitn = 0; first = 1'b1; rd_ph = 1'b0;
            sdr_sda = 1'b0;
        end else if (s_scl && ps_scl && !ps_sda && s_sda) begin
            sp_cnt++; in_xfer = 1'b0; sdr_sda = 1'b0;
        end else if (in_xfer && s_scl && !ps_scl) begin
            if (bitn < 8) begin
                shreg = {shreg[6:0], s_sda}; bitn++;
            end else if (bitn == 8) begin
                if (rd_ph) mack = !s_sda;
                bitn = 9;
            end
        end else if (in_xfer && !s_scl && ps_scl) begin
            if (bitn == 8) begin
                if (!rd_ph) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5", "unexpected slave byte", shreg, 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front(); t = tag_q.pop_front();
                        chk(shreg == e, t, "slave-side byte", shreg, e);
                    end
                    sdr_sda = 1'b1;   // ACK
                end else begin
                    sdr_sda = 1'b0;
                end
            end else if (bitn == 9) begin
                bitn = 0;
                if (first) begin
                    rd_ph = shreg[0]; first = 1'b0;
                    mack = 1'b1;
                end
                if (rd_ph && mack) begin
                    tx = rd_val; rd_val = rd_val + 8'h11;
                    sdr_sda = !tx[7];
                end else begin
                    sdr_sda = 1'b0;
                    if (rd_ph) in_xfer = 1'b0;
                end
            end else if (rd_ph && bitn >= 1 && bitn <= 7) begin
                sdr_sda = !tx[7-bitn];
            end
        end
        ps_scl = s_scl;
        ps_sda = s_sda;
    end

    // ---------------- master driver ----------------
    logic [7:0] exp_rd = 8'hA5;

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        mdr_sda = 1'b1; half(); mdr_scl = 1'b1; half();
    endtask

    task automatic m_rstart();
        mdr_sda = 1'b0; half(); mdr_scl = 1'b0; half();
        mdr_sda = 1'b1; half(); mdr_scl = 1'b1; half();
    endtask

    task automatic m_stop();
        mdr_sda = 1'b1; half(); mdr_scl = 1'b0; half(); mdr_sda = 1'b0; half();
    endtask

    task automatic wbit(input bit b);
        mdr_sda = !b; half(); mdr_scl = 1'b0; half(); mdr_scl = 1'b1;
    endtask

    task automatic rbit(output bit b);
        mdr_sda = 1'b0; half(); mdr_scl = 1'b0;
        repeat (Q/2) @(negedge clk);
        b = m_sda;
        repeat (Q - Q/2) @(negedge clk);
        mdr_scl = 1'b1;
    endtask

    task automatic wbyte(input logic [7:0] d, input logic [7:0] seen, input string tag);
        bit a;
        exp_q.push_back(seen); tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(a);
        chk(a == 1'b0, "R6", "ACK reflected to master", a, 0);
    endtask

    task automatic rbyte(input bit ack_it);
        logic [7:0] v;
        bit b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b); v[i] = b;
        end
        chk(v == exp_rd, "R7", "read byte at master", v, exp_rd);
        exp_rd = exp_rd + 8'h11;
        wbit(!ack_it);
        chk(mack == ack_it, "R7", "master ACK/NACK at slave", mack, ack_it);
    endtask

    task automatic do_enable(input logic [6:0] k, input bit pass);
        key_hi = k[6:4]; key_lo = k[3:0]; pass_req = pass;
        enable = 1'b0; repeat (3) @(negedge clk);
        enable = 1'b1;
        repeat (CAP + 3) @(negedge clk);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        int lows;
        int st0, sp0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R1", "ready in reset", ready, 0);
        chk({m_scl_oe, m_sda_oe, s_scl_oe, s_sda_oe} == 4'b0, "R1", "drives in reset",
            {m_scl_oe, m_sda_oe, s_scl_oe, s_sda_oe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12 / R1: master activity while disabled stays on its side
        lows = 0;
        fork
            begin
                m_start(); wbit(1'b0); wbit(1'b1); wbit(1'b0);
                mdr_sda = 1'b1; half(); mdr_scl = 1'b0; half(); mdr_sda = 1'b0; half();
            end
            begin
                repeat (9 * Q) begin
                    @(negedge clk);
                    if (!s_scl || !s_sda) lows++;
                end
            end
        join
        chk(lows == 0, "R12", "slave-side lows while not ready", lows, 0);
        chk(ready == 1'b0, "R1", "ready while enable low", ready, 0);

        // R2: capture window timing
        key_hi = 3'b101; key_lo = 4'b1010; pass_req = 1'b0;
        enable = 1'b1;
        repeat (CAP) @(negedge clk);
        chk(ready == 1'b0, "R2", "ready during capture window", ready, 0);
        repeat (2) @(negedge clk);
        chk(ready == 1'b1, "R2", "ready after capture window", ready, 1);
        repeat (Q) @(negedge clk);

        // R4 / R5 / R10: write transaction, key 0x5A
        st0 = st_cnt; sp0 = sp_cnt;
        m_start();
        wbyte({7'h21, 1'b0}, {7'h21 ^ 7'h5A, 1'b0}, "R4");
        wbyte(8'h3C, 8'h3C, "R5");
        wbyte(8'hC3, 8'hC3, "R5");
        m_stop();
        chk(st_cnt == st0 + 1, "R10", "START on slave side", st_cnt - st0, 1);
        chk(sp_cnt == sp0 + 1, "R10", "STOP on slave side", sp_cnt - sp0, 1);

        // R7: read transaction, ACK then NACK
        m_start();
        wbyte({7'h21, 1'b1}, {7'h21 ^ 7'h5A, 1'b1}, "R5");
        rbyte(1'b1);
        rbyte(1'b0);
        m_stop();

        // R9: write, repeated START, read with translated address
        m_start();
        wbyte({7'h7F, 1'b0}, {7'h7F ^ 7'h5A, 1'b0}, "R4");
        wbyte(8'h00, 8'h00, "R5");
        m_rstart();
        wbyte({7'h7F, 1'b1}, {7'h7F ^ 7'h5A, 1'b1}, "R9");
        rbyte(1'b0);
        m_stop();

        // R3: late key change ignored
        key_hi = 3'b000; key_lo = 4'b1111;
        repeat (Q) @(negedge clk);
        m_start();
        wbyte({7'h00, 1'b0}, {7'h5A, 1'b0}, "R3");
        m_stop();

        // R1: disable cuts the links
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R1", "ready after disable", ready, 0);
        chk({m_scl_oe, m_sda_oe, s_scl_oe, s_sda_oe} == 4'b0, "R1", "drives after disable",
            {m_scl_oe, m_sda_oe, s_scl_oe, s_sda_oe}, 0);

        // R3: new key takes effect on the next enable rise
        do_enable(7'h0F, 1'b0);
        chk(ready == 1'b1, "R2", "ready after re-enable", ready, 1);
        m_start();
        wbyte({7'h00, 1'b0}, {7'h0F, 1'b0}, "R3");
        wbyte({7'h55, 1'b0}, {7'h55, 1'b0}, "R5");
        m_stop();

        // R8: pass-through
        do_enable(7'h7F, 1'b1);
        m_start();
        wbyte({7'h55, 1'b0}, {7'h55, 1'b0}, "R8");
        m_rstart();
        wbyte({7'h2A, 1'b1}, {7'h2A, 1'b1}, "R8");
        rbyte(1'b0);
        m_stop();

        // R11: slave holds SCL low on an idle bus
        repeat (Q) @(negedge clk);
        sdr_scl = 1'b1;
        repeat (4) @(negedge clk);
        chk(m_scl == 1'b0, "R11", "master SCL while slave holds", m_scl, 0);
        sdr_scl = 1'b0;
        repeat (4) @(negedge clk);
        chk(m_scl == 1'b1, "R11", "master SCL after release", m_scl, 1);

        chk(exp_q.size() == 0, "R5", "bytes never seen on slave side", exp_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule